// File: doc/BRIEF.md
# Protection region configuration bank

This block keeps one configuration byte per memory protection region and passes every software write through a legalizer before it is stored. Unsupported encodings are never stored. Either the field keeps its old value or the write is dropped, so a read always returns a byte the hardware accepts. The bank has one byte-wide write port that takes an entry index, and one registered read port. A static enable input turns the two-bit memory-type field on or off. A static granularity parameter decides whether the four-byte matching mode is available.

The stored permission, matching-mode, lock and memory-type fields of every entry are exported in parallel to the region checking logic further down the path. The memory-type field is kept and can be read back. It has no effect on the permission, mode or lock outputs.

Top module: `pmpcfg_bank`

## Requirements
- R1: The byte layout is bit 0 read, bit 1 write, bit 2 execute, bits 4:3 matching mode (0 off, 1 top-of-range, 2 four-byte aligned, 3 power-of-two aligned), bits 6:5 memory type, bit 7 lock. The fields of entry i appear on the export ports at slice i: perm bits [3i+2:3i] as {x,w,r}, mode [2i+1:2i], mt [2i+1:2i], lock [i].
- R2: An active reset clears every entry to 0x00. That byte means off, no permissions, memory type 0 and unlocked.
- R3: When `mt_en` is 0, bits 6:5 of a write are stored as 0.
- R4: When `mt_en` is 1 and a write carries memory-type code 3, the entry keeps its previous memory type. All other fields of that write are still stored.
- R5: When `mt_en` is 1 and the written memory-type code is 0, 1 or 2, that code is stored as written.
- R6: With `GRAN` of 1 or more, a write that selects mode 2 keeps the entry's previous mode and applies its other fields. With `GRAN` of 0, mode 2 is stored as written.
- R7: A write to an entry whose lock bit is set is ignored completely. Only reset clears the lock bit.
- R8: The memory-type field has no effect on the exported permission, mode or lock values.
- R9: A write changes only the entry it indexes. `rd_data` is registered and, one clock edge after the write, shows the legalized byte of the entry chosen by `rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mt_en | input | 1 | Static enable for the memory-type field |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Entry written |
| wr_data | input | 8 | Raw configuration byte |
| rd_idx | input | IDX_W | Entry read |
| rd_data | output | 8 | Registered legalized byte of the entry chosen by rd_idx |
| entry_perm_o | output | 3*NUM_ENTRIES | {x,w,r} per entry |
| entry_mode_o | output | 2*NUM_ENTRIES | Matching mode per entry |
| entry_mt_o | output | 2*NUM_ENTRIES | Memory type per entry |
| entry_lock_o | output | NUM_ENTRIES | Lock bit per entry |

## Verification
An entry register loads on the clock edge where `wr_en` is high, so the export ports show the new fields straight after that edge. The read register loads on the same edge, so it still shows the old byte there, and the new byte appears one edge later. The bench drives its inputs on falling edges. It samples reads one full cycle after it sets `rd_idx`, and it also checks once that the read is still stale directly after a write. The lock and reserved-code cases are each checked by a write followed by a read-back of the entry it targeted.

// File: rtl/pmpcfg_pkg.sv
package pmpcfg_pkg;

  typedef struct packed {
    logic       lock;
    logic [1:0] mt;
    logic [1:0] mode;
    logic       x;
    logic       w;
    logic       r;
  } cfg_t;

  localparam logic [1:0] MODE_NA4   = 2'd2;
  localparam logic [1:0] MT_RSVD    = 2'd3;
  localparam int         CFG_W      = $bits(cfg_t);

endpackage

// File: rtl/pmpcfg_legalize.sv
module pmpcfg_legalize
  import pmpcfg_pkg::*;
#(
  parameter int GRAN = 0
) (
  input  cfg_t cur_i,
  input  cfg_t raw_i,
  input  logic mt_en_i,
  output cfg_t nxt_o,
  output logic accept_o
);

  always_comb begin
    nxt_o    = raw_i;
    accept_o = !cur_i.lock;
    if (!mt_en_i) begin
      nxt_o.mt = 2'd0;
    end else if (raw_i.mt == MT_RSVD) begin
      nxt_o.mt = cur_i.mt;
    end
    if ((GRAN >= 1) && (raw_i.mode == MODE_NA4)) begin
      nxt_o.mode = cur_i.mode;
    end
  end

endmodule

// File: rtl/pmpcfg_entry.sv
module pmpcfg_entry
  import pmpcfg_pkg::*;
#(
  parameter int GRAN = 0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sel_i,
  input  cfg_t raw_i,
  input  logic mt_en_i,
  output cfg_t q_o
);

  cfg_t q_r;
  cfg_t q_nxt;
  cfg_t legal;
  logic accept;
  logic load;

  pmpcfg_legalize #(.GRAN(GRAN)) u_legal (
    .cur_i    (q_r),
    .raw_i    (raw_i),
    .mt_en_i  (mt_en_i),
    .nxt_o    (legal),
    .accept_o (accept)
  );

  assign load = sel_i && accept;

  always_comb begin
    q_nxt = q_r;
    if (load) q_nxt = legal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_r <= '0;
    else        q_r <= q_nxt;
  end

  assign q_o = q_r;

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_r.lock |=> $stable(q_r));

  // R3
  mt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !q_r.lock && !mt_en_i) |=> (q_r.mt == 2'd0));

  // R4
  mt_rsvd_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !q_r.lock && mt_en_i && raw_i.mt == MT_RSVD) |=> $stable(q_r.mt));

  // R5
  mt_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !q_r.lock && mt_en_i && raw_i.mt != MT_RSVD) |=> (q_r.mt == $past(raw_i.mt)));

  // R6
  no_na4_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (GRAN >= 1) |-> (q_r.mode != MODE_NA4));

  // R8
  perm_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_i && !q_r.lock) |=> ({q_r.x, q_r.w, q_r.r} == $past({raw_i.x, raw_i.w, raw_i.r})));

endmodule

// File: rtl/pmpcfg_bank.sv
module pmpcfg_bank
  import pmpcfg_pkg::*;
#(
  parameter int NUM_ENTRIES = 8,
  parameter int GRAN        = 0,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     mt_en,
  input  logic                     wr_en,
  input  logic [IDX_W-1:0]         wr_idx,
  input  logic [CFG_W-1:0]         wr_data,
  input  logic [IDX_W-1:0]         rd_idx,
  output logic [CFG_W-1:0]         rd_data,
  output logic [3*NUM_ENTRIES-1:0] entry_perm_o,
  output logic [2*NUM_ENTRIES-1:0] entry_mode_o,
  output logic [2*NUM_ENTRIES-1:0] entry_mt_o,
  output logic [NUM_ENTRIES-1:0]   entry_lock_o
);

  cfg_t             ent_q [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] sel;
  logic [CFG_W-1:0] rd_q;
  logic [CFG_W-1:0] rd_nxt;

  for (genvar i = 0; i < NUM_ENTRIES; i++) begin : g_ent
    assign sel[i] = wr_en && (wr_idx == IDX_W'(i));

    pmpcfg_entry #(.GRAN(GRAN)) u_entry (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_i   (sel[i]),
      .raw_i   (cfg_t'(wr_data)),
      .mt_en_i (mt_en),
      .q_o     (ent_q[i])
    );

    assign entry_perm_o[3*i +: 3] = {ent_q[i].x, ent_q[i].w, ent_q[i].r};
    assign entry_mode_o[2*i +: 2] = ent_q[i].mode;
    assign entry_mt_o[2*i +: 2]   = ent_q[i].mt;
    assign entry_lock_o[i]        = ent_q[i].lock;
  end

  always_comb begin
    rd_nxt = '0;
    for (int k = 0; k < NUM_ENTRIES; k++) begin
      if (rd_idx == IDX_W'(k)) rd_nxt = ent_q[k];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_nxt;
  end

  assign rd_data = rd_q;

  // R9
  one_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sel));

  // R9
  rd_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && $stable(rd_idx)) |=> (rd_data == $past(rd_data) || $past(wr_en,2)));

endmodule

// File: tb/pmpcfg_bank_tb.sv
module pmpcfg_bank_tb;

  localparam int N     = 8;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic mt_en;
  logic wr_en, g_wr_en;
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic [7:0] wr_data;
  logic [7:0] rd_data, g_rd_data;
  logic [3*N-1:0] perm, g_perm;
  logic [2*N-1:0] mode, g_mode, mt, g_mt;
  logic [N-1:0]   lock, g_lock;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  pmpcfg_bank #(.NUM_ENTRIES(N), .GRAN(0)) u_dut (
    .clk(clk), .rst_n(rst_n), .mt_en(mt_en), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .entry_perm_o(perm), .entry_mode_o(mode), .entry_mt_o(mt), .entry_lock_o(lock)
  );

  pmpcfg_bank #(.NUM_ENTRIES(N), .GRAN(2)) u_dut_g (
    .clk(clk), .rst_n(rst_n), .mt_en(mt_en), .wr_en(g_wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(g_rd_data),
    .entry_perm_o(g_perm), .entry_mode_o(g_mode), .entry_mt_o(g_mt), .entry_lock_o(g_lock)
  );

  // {idx[3], data[8], mt_en[1], expected[8]}
  localparam int NV = 12;
  localparam logic [19:0] VEC [NV] = '{
    {3'd0, 8'h0F, 1'b1, 8'h0F},  // R1 rwx, top-of-range
    {3'd1, 8'h3F, 1'b1, 8'h3F},  // R5 mt=1
    {3'd1, 8'h61, 1'b1, 8'h21},  // R4 reserved keeps mt=1
    {3'd2, 8'h41, 1'b0, 8'h01},  // R3 disabled clears mt
    {3'd2, 8'h51, 1'b1, 8'h51},  // R5 mt=2, R6 four-byte mode allowed with GRAN=0
    {3'd3, 8'h79, 1'b1, 8'h19},  // R4 reserved keeps mt=0
    {3'd4, 8'h83, 1'b1, 8'h83},  // R7 set lock
    {3'd4, 8'h07, 1'b1, 8'h83},  // R7 locked write ignored
    {3'd5, 8'hE0, 1'b1, 8'h80},  // R4 with lock
    {3'd5, 8'h01, 1'b1, 8'h80},  // R7 locked write ignored
    {3'd7, 8'h47, 1'b0, 8'h07},  // R3
    {3'd6, 8'h1D, 1'b1, 8'h1D}   // R5 mt=0
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input bit g, input logic [2:0] idx, input logic [7:0] d, input logic me);
    @(negedge clk);
    wr_idx = idx; wr_data = d; mt_en = me;
    if (g) g_wr_en = 1'b1; else wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; g_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] idx);
    rd_idx = idx;
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    wr_en = 0; g_wr_en = 0; wr_idx = 0; wr_data = 0; rd_idx = 0; mt_en = 1;
    do_reset();

    // R2 reset state
    for (int i = 0; i < N; i++) begin
      rd(3'(i));
      check("R2 reset read", {24'd0, rd_data}, 32'h0);
    end
    check("R2 reset exports", {perm, mode, mt, lock}, 32'h0);

    for (int v = 0; v < NV; v++) begin
      wr(1'b0, VEC[v][19:17], VEC[v][16:9], VEC[v][8]);
      rd(VEC[v][19:17]);
      check($sformatf("R1 vector %0d", v), {24'd0, rd_data}, {24'd0, VEC[v][7:0]});
    end

    // R9 other entries untouched: entry 0 still 0x0F
    rd(3'd0);
    check("R9 isolation", {24'd0, rd_data}, 32'h0F);

    // R1 export slices of entry 1 (0x21) and 4 (0x83)
    check("R1 perm entry1", {29'd0, perm[5:3]}, 32'h1);
    check("R1 mt entry1", {30'd0, mt[3:2]}, 32'h1);
    check("R1 lock entry4", {31'd0, lock[4]}, 32'h1);
    check("R1 mode entry2", {30'd0, mode[5:4]}, 32'h2);

    // R8 memory-type change leaves perm/mode/lock exports alone
    wr(1'b0, 3'd0, 8'h4F, 1'b1);
    check("R8 perm", {29'd0, perm[2:0]}, 32'h7);
    check("R8 mode", {30'd0, mode[1:0]}, 32'h1);
    check("R8 lock", {31'd0, lock[0]}, 32'h0);
    check("R8 mt stored", {30'd0, mt[1:0]}, 32'h2);

    // R9 read latency: same edge shows old value, next edge new value
    rd_idx = 3'd6;
    @(negedge clk);
    wr_idx = 3'd6; wr_data = 8'h05; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R9 stale read", {24'd0, rd_data}, 32'h1D);
    @(negedge clk);
    check("R9 fresh read", {24'd0, rd_data}, 32'h05);

    // R6 coarse granularity instance
    wr(1'b1, 3'd0, 8'h17, 1'b1);
    rd(3'd0);
    check("R6 na4 from off", {24'd0, g_rd_data}, 32'h07);
    wr(1'b1, 3'd0, 8'h0F, 1'b1);
    wr(1'b1, 3'd0, 8'h13, 1'b1);
    rd(3'd0);
    check("R6 na4 keeps tor", {24'd0, g_rd_data}, 32'h0B);

    // R7 reset releases lock
    do_reset();
    rd(3'd4);
    check("R7 reset clears lock", {24'd0, rd_data}, 32'h0);
    wr(1'b0, 3'd4, 8'h05, 1'b1);
    rd(3'd4);
    check("R7 writable after reset", {24'd0, rd_data}, 32'h05);

    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule